// File: doc/BRIEF.md
# Privileged CSR Update Checker

This block watches the stream of control/status-register update records that a processor trace port emits. Each record names a CSR (12-bit number), gives an update kind (full write, bit set or bit clear) and carries a data word. A table of eight protected-register slots holds, for each slot, a CSR number, a legal value, a compare mask and an enable bit. For every record that targets an enabled slot, the block rebuilds the value the register will hold after the update and compares it, under the slot's mask, with the legal value. A mismatch raises a one-cycle alarm carrying the slot index. A match ends the check quietly.

A set or clear update only names the bits it changes, so each slot keeps a shadow copy of its register. Writing a slot's configuration loads the shadow with the legal value. After that, every applied update replaces the shadow with the rebuilt value, whether or not that value was legal. Typical slots guard the supervisor status register, with the mask covering the bit that lets loads and stores run at another privilege level, and the page-table root register, with a full mask.

Records arrive on a valid/ready channel. The block accepts a record whenever `rec_ready` is high. `rec_ready` drops only in a cycle where the configuration port is writing. The producer must then hold the record until a cycle in which ready is high. Configuration pins are plain, with no handshake.

Top module: `csr_update_checker`

## Requirements
- R1: After reset, `alarm` is low, `rec_ready` is high and every slot is disabled, so no record raises an alarm.
- R2: While `cfg_we` is high, `rec_ready` is low and no record is accepted. A record is accepted only in a cycle where `rec_valid` and `rec_ready` are both high.
- R3: Kind code 0 (full write): the rebuilt value is the record data. If a bit set in the slot's mask differs from the legal value, `alarm` is high in the cycle after acceptance and `alarm_slot` gives that slot index.
- R4: Kind code 1 (set): the rebuilt value is the shadow OR the record data.
- R5: Kind code 2 (clear): the rebuilt value is the shadow AND the inverse of the record data.
- R6: Kind code 3 is reserved. Such a record is accepted but raises no alarm and leaves every shadow unchanged.
- R7: A record whose CSR number matches no enabled slot raises no alarm. Writing a slot with `cfg_en` low disables that slot.
- R8: Bits outside a slot's mask never cause an alarm.
- R9: An accepted record whose rebuilt value matches under the mask leaves `alarm` low in the next cycle.
- R10: When several enabled slots share a CSR number and more than one of them flags a mismatch, `alarm_slot` reports the lowest index among them.
- R11: A configuration write loads the slot's shadow with `cfg_legal`. Every applied update (kinds 0 to 2 on a matching enabled slot) stores the rebuilt value into the shadow, including an update that raised an alarm.
- R12: `alarm` is high only in the cycle after a violating acceptance. Back-to-back violating records give back-to-back alarm cycles, and a cycle with no acceptance is followed by `alarm` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Update record present |
| rec_ready | output | 1 | Record accepted this cycle when high with rec_valid |
| rec_csr | input | 12 | CSR number of the record |
| rec_kind | input | 2 | Update kind: 0 write, 1 set, 2 clear, 3 reserved |
| rec_data | input | 32 | Record data word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 3 | Slot being written |
| cfg_csr | input | 12 | CSR number for the slot |
| cfg_legal | input | 32 | Legal value for the slot (also initial shadow) |
| cfg_mask | input | 32 | Compare mask for the slot |
| cfg_en | input | 1 | Slot enable |
| alarm | output | 1 | Violation detected on the record accepted last cycle |
| alarm_slot | output | 3 | Index of the violating slot, meaningful while alarm is high |

## Verification
The bench runs a set followed by a clear of the privilege-modify bit, so the rebuilt value must come from the shadow. A design that compared raw record data would alarm on the clear or stay silent on the set. A reserved-kind record carrying all ones is followed by a neutral set: a design that let the reserved record touch the shadow would change the result of that set. Two slots share one CSR number, and a design without lowest-index priority reports the wrong slot. A violating record presented during a configuration write must not be taken, and a design that ignored back-pressure would raise an alarm there. Further checks cover a record after its slot is disabled, back-to-back violations, and a pseudo-random record mix that is compared against a behavioural model on every clock.

// File: rtl/csr_guard_pkg.sv
package csr_guard_pkg;

  typedef enum logic [1:0] {
    UPD_WRITE = 2'd0,
    UPD_SET   = 2'd1,
    UPD_CLEAR = 2'd2,
    UPD_RSVD  = 2'd3
  } upd_kind_e;

endpackage

// File: rtl/csr_guard_slot.sv
module csr_guard_slot
  import csr_guard_pkg::*;
#(
  parameter int NUM_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic [NUM_W-1:0]  cfg_csr,
  input  logic [DATA_W-1:0] cfg_legal,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic              cfg_en,
  input  logic              rec_fire,
  input  logic [NUM_W-1:0]  rec_csr,
  input  upd_kind_e         rec_kind,
  input  logic [DATA_W-1:0] rec_data,
  output logic              hit,
  output logic              viol
);

  logic              en_q;
  logic [NUM_W-1:0]  csr_q;
  logic [DATA_W-1:0] legal_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] next_val;

  // value the protected register will hold after this record
  always_comb begin
    case (rec_kind)
      UPD_WRITE: next_val = rec_data;
      UPD_SET:   next_val = shadow_q | rec_data;
      UPD_CLEAR: next_val = shadow_q & ~rec_data;
      default:   next_val = shadow_q;
    endcase
  end

  assign hit  = en_q && (csr_q == rec_csr) && (rec_kind != UPD_RSVD);
  assign viol = hit && (|((next_val ^ legal_q) & mask_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      csr_q    <= '0;
      legal_q  <= '0;
      mask_q   <= '0;
      shadow_q <= '0;
    end else if (cfg_sel) begin
      en_q     <= cfg_en;
      csr_q    <= cfg_csr;
      legal_q  <= cfg_legal;
      mask_q   <= cfg_mask;
      shadow_q <= cfg_legal;
    end else if (rec_fire && hit) begin
      shadow_q <= next_val;
    end
  end

endmodule

// File: rtl/csr_guard_pick.sv
module csr_guard_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // lowest set index wins
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/csr_update_checker.sv
module csr_update_checker
  import csr_guard_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NUM_W   = 12,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [NUM_W-1:0]  rec_csr,
  input  logic [1:0]        rec_kind,
  input  logic [DATA_W-1:0] rec_data,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_slot,
  input  logic [NUM_W-1:0]  cfg_csr,
  input  logic [DATA_W-1:0] cfg_legal,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic              cfg_en,
  output logic              alarm,
  output logic [IDX_W-1:0]  alarm_slot
);

  logic               rec_fire;
  upd_kind_e          kind;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] viol_vec;
  logic               viol_any;
  logic [IDX_W-1:0]   viol_idx;
  logic               alarm_q;
  logic [IDX_W-1:0]   alarm_slot_q;

  assign rec_ready = !cfg_we;
  assign rec_fire  = rec_valid && rec_ready;
  assign kind      = upd_kind_e'(rec_kind);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    csr_guard_slot #(
      .NUM_W  (NUM_W),
      .DATA_W (DATA_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_sel   (cfg_we && (cfg_slot == IDX_W'(g))),
      .cfg_csr   (cfg_csr),
      .cfg_legal (cfg_legal),
      .cfg_mask  (cfg_mask),
      .cfg_en    (cfg_en),
      .rec_fire  (rec_fire),
      .rec_csr   (rec_csr),
      .rec_kind  (kind),
      .rec_data  (rec_data),
      .hit       (hit_vec[g]),
      .viol      (viol_vec[g])
    );
  end

  csr_guard_pick #(
    .N     (ENTRIES),
    .IDX_W (IDX_W)
  ) u_pick (
    .req (viol_vec),
    .any (viol_any),
    .idx (viol_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q      <= 1'b0;
      alarm_slot_q <= '0;
    end else begin
      alarm_q <= rec_fire && viol_any;
      if (rec_fire && viol_any) begin
        alarm_slot_q <= viol_idx;
      end
    end
  end

  assign alarm      = alarm_q;
  assign alarm_slot = alarm_slot_q;

endmodule

// File: rtl/csr_guard_chk.sv
module csr_guard_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rec_valid,
  input logic               rec_ready,
  input logic [1:0]         rec_kind,
  input logic               cfg_we,
  input logic               alarm,
  input logic [ENTRIES-1:0] hit_vec
);

  // R2
  cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !rec_ready);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_valid && rec_ready) |=> !alarm);

  // R6
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready && rec_kind == 2'd3) |=> !alarm);

  // R7
  nohit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready && hit_vec == '0) |=> !alarm);

  // R3
  alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> $past(rec_valid && rec_ready));

endmodule

bind csr_update_checker csr_guard_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rec_valid (rec_valid),
  .rec_ready (rec_ready),
  .rec_kind  (rec_kind),
  .cfg_we    (cfg_we),
  .alarm     (alarm),
  .hit_vec   (hit_vec)
);

// File: tb/csr_update_checker_test.sv
module csr_update_checker_test;
  localparam int N  = 8;
  localparam int NW = 12;
  localparam int DW = 32;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          rec_valid = 1'b0;
  logic          rec_ready;
  logic [NW-1:0] rec_csr = '0;
  logic [1:0]    rec_kind = '0;
  logic [DW-1:0] rec_data = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_slot = '0;
  logic [NW-1:0] cfg_csr = '0;
  logic [DW-1:0] cfg_legal = '0;
  logic [DW-1:0] cfg_mask = '0;
  logic          cfg_en = 1'b0;
  logic          alarm;
  logic [IW-1:0] alarm_slot;

  csr_update_checker uut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_csr(rec_csr), .rec_kind(rec_kind), .rec_data(rec_data),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_csr(cfg_csr),
    .cfg_legal(cfg_legal), .cfg_mask(cfg_mask), .cfg_en(cfg_en),
    .alarm(alarm), .alarm_slot(alarm_slot)
  );

  int checks = 0;
  int fails  = 0;

  logic [NW-1:0] m_csr[N];
  logic [DW-1:0] m_legal[N];
  logic [DW-1:0] m_mask[N];
  logic [DW-1:0] m_shadow[N];
  bit            m_en[N];
  bit            exp_alarm;
  int            exp_slot;

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void model_rec(input logic [NW-1:0] c, input logic [1:0] k,
                                    input logic [DW-1:0] d);
    logic [DW-1:0] nv;
    exp_alarm = 1'b0;
    exp_slot  = 0;
    for (int i = 0; i < N; i++) begin
      if (m_en[i] && m_csr[i] == c && k != 2'd3) begin
        if (k == 2'd0)      nv = d;
        else if (k == 2'd1) nv = m_shadow[i] | d;
        else                nv = m_shadow[i] & ~d;
        if ((((nv ^ m_legal[i]) & m_mask[i]) != 0) && !exp_alarm) begin
          exp_alarm = 1'b1;
          exp_slot  = i;
        end
        m_shadow[i] = nv;
      end
    end
  endfunction

  // compare outputs one settle step after the edge
  task automatic settle(input string tag);
    @(posedge clk);
    #1;
    check(tag, "alarm", 64'(alarm), 64'(exp_alarm));
    if (exp_alarm) check(tag, "alarm_slot", 64'(alarm_slot), 64'(exp_slot));
  endtask

  task automatic rec(input string tag, input logic [NW-1:0] c, input logic [1:0] k,
                     input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b0; rec_valid = 1'b1; rec_csr = c; rec_kind = k; rec_data = d;
    #0.1;
    check(tag, "rec_ready", 64'(rec_ready), 64'd1);
    model_rec(c, k, d);
    settle(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    cfg_we = 1'b0; rec_valid = 1'b0;
    exp_alarm = 1'b0;
    settle(tag);
  endtask

  task automatic cfg(input string tag, input int s, input logic [NW-1:0] c,
                     input logic [DW-1:0] lg, input logic [DW-1:0] mk, input bit en,
                     input bit with_rec, input logic [NW-1:0] rc, input logic [DW-1:0] rd);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = IW'(s); cfg_csr = c; cfg_legal = lg; cfg_mask = mk; cfg_en = en;
    rec_valid = with_rec; rec_csr = rc; rec_kind = 2'd0; rec_data = rd;
    #0.1;
    check(tag, "rec_ready during config", 64'(rec_ready), 64'd0);
    m_csr[s] = c; m_legal[s] = lg; m_mask[s] = mk; m_en[s] = en; m_shadow[s] = lg;
    exp_alarm = 1'b0;
    settle(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int unsigned lcg;
    for (int i = 0; i < N; i++) begin
      m_en[i] = 1'b0; m_csr[i] = '0; m_legal[i] = '0; m_mask[i] = '0; m_shadow[i] = '0;
    end
    exp_alarm = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.1;
    // R1 reset state
    check("R1", "alarm after reset", 64'(alarm), 64'd0);
    check("R1", "rec_ready after reset", 64'(rec_ready), 64'd1);
    rec("R1", 12'h180, 2'd0, 32'hDEAD_0000);

    // page-table root in slot 2, status register in slots 0 and 5
    cfg("R11", 2, 12'h180, 32'h8000_1234, 32'hFFFF_FFFF, 1'b1, 1'b0, '0, '0);
    cfg("R11", 0, 12'h100, 32'h0000_0000, 32'h0002_0000, 1'b1, 1'b0, '0, '0);
    cfg("R11", 5, 12'h100, 32'h0000_0002, 32'h0002_0002, 1'b1, 1'b0, '0, '0);
    // R2: violating record offered during a config write is not taken
    cfg("R2", 7, 12'h300, 32'h0, 32'h0, 1'b0, 1'b1, 12'h180, 32'h0BAD_0BAD);

    rec("R9", 12'h180, 2'd0, 32'h8000_1234);
    rec("R3", 12'h180, 2'd0, 32'h8000_1235);
    idle("R12");
    // set privilege-modify bit: slots 0 and 5 both flag, lowest wins
    rec("R10", 12'h100, 2'd1, 32'h0002_0000);
    rec("R5", 12'h100, 2'd2, 32'h0002_0000);
    rec("R8", 12'h100, 2'd1, 32'h0000_0001);
    rec("R5", 12'h100, 2'd2, 32'h0000_0002);
    rec("R6", 12'h100, 2'd3, 32'hFFFF_FFFF);
    rec("R4", 12'h100, 2'd1, 32'h0000_0000);
    rec("R4", 12'h100, 2'd1, 32'h0000_0002);
    // R11: a violating write still lands in the shadow
    rec("R11", 12'h100, 2'd0, 32'h0002_0002);
    rec("R11", 12'h100, 2'd2, 32'h0002_0000);
    rec("R7", 12'h300, 2'd0, 32'hFFFF_FFFF);
    // R12: back-to-back violations then quiet
    rec("R12", 12'h180, 2'd0, 32'h0000_0000);
    rec("R12", 12'h180, 2'd1, 32'h0000_0001);
    idle("R12");
    // R7: disabled slot ignores records
    cfg("R7", 2, 12'h180, 32'h8000_1234, 32'hFFFF_FFFF, 1'b0, 1'b0, '0, '0);
    rec("R7", 12'h180, 2'd0, 32'h0000_0000);
    cfg("R3", 2, 12'h180, 32'h8000_1234, 32'hFFFF_0000, 1'b1, 1'b0, '0, '0);

    lcg = 32'h1234_5678;
    for (int n = 0; n < 60; n++) begin
      logic [NW-1:0] c;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      case (lcg[31:30])
        2'd0: c = 12'h100;
        2'd1: c = 12'h180;
        2'd2: c = 12'h300;
        default: c = 12'h100;
      endcase
      if (lcg[5]) rec("R3", c, lcg[29:28], {lcg[27:12] ^ 16'h8000, lcg[15:0] & 16'h0003} | 32'h0002_0000 & {32{lcg[7]}});
      else idle("R12");
    end
    idle("R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule